// File: doc/BRIEF.md
# Fused Read-Modify-Write ALU

This execution unit serves an 8-bit accumulator processor. It performs, in one step, the fused operations that first change a memory operand and then feed the changed value into an accumulator operation. The changes are a shift, a rotate, an increment or a decrement, and the new value is also returned for write-back. The unit also covers several immediate forms: AND followed by a shift or rotate of A, AND followed by copying the sign into carry, and a subtract from the masked X. It also handles the combined loads and stores of A and X, and the OR-with-constant load whose zero argument clears both registers.

The caller presents an operation code, A, X, the fetched operand and the current N, Z, C, V and D flags, with `in_valid` high. One clock later the unit presents the registered new A, new X, the write-back byte with its write strobe, and the new flags. The caller handles address generation, operand fetch and bus timing. All arithmetic is binary, whatever the value of D.

Top module: `rmw_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero at that edge, including `out_valid` and `m_we`.
- R2: The outputs of an operation appear at the clock edge after the one where `in_valid` is high, and `out_valid` is then high. After an edge with `in_valid` low, `out_valid` and `m_we` are low, and A, X, memory and flag outputs keep their values.
- R3: Codes 0, 1 and 2 shift left (0 fills bit 0), rotate left through C, and shift right (0 fills bit 7). The shifted value is written back and combined into A with OR, AND and XOR respectively. C takes the bit that was shifted out, and N and Z follow the new A.
- R4: Code 3 rotates the operand right through C and writes it back. It then adds the rotated value to A, using the bit rotated out as the carry in. C is the carry out, V is the signed overflow, and N and Z follow the new A.
- R5: Code 4 writes back the operand minus one and compares A with it. A is unchanged, C = 1 when A is not less than the new value, and N and Z follow the 8-bit difference.
- R6: Code 5 writes back the operand plus one and sets A to A minus the new value minus (1 - C). C = 1 when there is no borrow, V is the signed overflow, and N and Z follow A.
- R7: Codes 6, 7 and 8 form t = A AND operand. Code 6 sets A = t and C = bit 7 of t. Code 7 sets A = t shifted right and C = bit 0 of t. Code 8 sets A = {C, t[7:1]}, C = bit 6 of the new A and V = bit 6 XOR bit 5 of the new A. N and Z follow A.
- R8: Code 9 sets X = (A AND X) minus the operand, leaves A unchanged, sets C = 1 when there is no borrow, and sets N and Z from the new X.
- R9: Code 10 loads the operand into both A and X, with N and Z from it. Code 11 writes A AND X back to memory and leaves A, X, N, Z, C and V unchanged.
- R10: Code 12 sets both A and X to (A OR `LXA_MIX`) AND operand, with N and Z from the result. A zero operand therefore clears both A and X.
- R11: The D input has no effect on any result. All sums and differences are binary.
- R12: `m_we` is high only for codes 0 to 5 and 11. Codes 13 to 15 leave A, X and all flags at their input values and write nothing.
- R13: V changes only for codes 3, 5 and 8. For every other code `v_out` equals `v_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Operation code |
| a_in | input | W | Accumulator |
| x_in | input | W | X register |
| m_in | input | W | Memory or immediate operand |
| n_in | input | 1 | Current N flag |
| z_in | input | 1 | Current Z flag |
| c_in | input | 1 | Current C flag |
| v_in | input | 1 | Current V flag |
| d_in | input | 1 | Current D flag (ignored) |
| out_valid | output | 1 | Results valid |
| a_out | output | W | New accumulator |
| x_out | output | W | New X register |
| m_out | output | W | Write-back value |
| m_we | output | 1 | Write-back strobe |
| n_out | output | 1 | New N flag |
| z_out | output | 1 | New Z flag |
| c_out | output | 1 | New C flag |
| v_out | output | 1 | New V flag |

## Verification
The unit keeps no state beyond its single output register, so any fault shows on the very next `out_valid` cycle. A wrong shifted-out bit, a wrong adder carry-in or a swapped operand shows as a wrong write-back byte, a wrong A or X, or a wrong C or V. A fault in the shared adder's operand select separates the compare, subtract and masked X forms, and shows in C and in the N and Z flags. A strobe or hold fault shows as `m_we` high for a non-writing code, or as outputs that change during an idle cycle.

// File: rtl/rmw_alu_pkg.sv
package rmw_alu_pkg;
  typedef enum logic [3:0] {
    OP_SLO = 4'd0,
    OP_RLA = 4'd1,
    OP_SRE = 4'd2,
    OP_RRA = 4'd3,
    OP_DCP = 4'd4,
    OP_ISC = 4'd5,
    OP_ANC = 4'd6,
    OP_ASR = 4'd7,
    OP_ARR = 4'd8,
    OP_SBX = 4'd9,
    OP_LAX = 4'd10,
    OP_SAX = 4'd11,
    OP_LXA = 4'd12
  } fused_op_e;
endpackage

// File: rtl/rmw_mem_unit.sv
module rmw_mem_unit
  import rmw_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  fused_op_e      op,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   m_in,
  input  logic           c_in,
  output logic [W-1:0]   m_new,
  output logic           c_mod,
  output logic           we
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    m_new = m_in;
    c_mod = c_in;
    we    = 1'b0;
    unique case (op)
      OP_SLO: begin m_new = {m_in[W-2:0], 1'b0}; c_mod = m_in[W-1]; we = 1'b1; end
      OP_RLA: begin m_new = {m_in[W-2:0], c_in}; c_mod = m_in[W-1]; we = 1'b1; end
      OP_SRE: begin m_new = {1'b0, m_in[W-1:1]}; c_mod = m_in[0];   we = 1'b1; end
      OP_RRA: begin m_new = {c_in, m_in[W-1:1]}; c_mod = m_in[0];   we = 1'b1; end
      OP_DCP: begin m_new = m_in - ONE; we = 1'b1; end
      OP_ISC: begin m_new = m_in + ONE; we = 1'b1; end
      OP_SAX: begin m_new = a_in & x_in; we = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/rmw_acc_unit.sv
module rmw_acc_unit
  import rmw_alu_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] LXA_MIX = '1
) (
  input  fused_op_e      op,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   m_in,
  input  logic [W-1:0]   m_new,
  input  logic           c_mod,
  input  logic           n_in,
  input  logic           z_in,
  input  logic           c_in,
  input  logic           v_in,
  output logic [W-1:0]   a_nx,
  output logic [W-1:0]   x_nx,
  output logic           n_nx,
  output logic           z_nx,
  output logic           c_nx,
  output logic           v_nx
);
  logic [W-1:0] lhs, rhs, masked, nz_src;
  logic         cin, set_nz, ovf;
  logic [W:0]   sum;

  // one shared adder serves add, subtract, compare and masked-X subtract
  always_comb begin
    lhs = a_in;
    rhs = ~m_new;
    cin = 1'b1;
    unique case (op)
      OP_RRA: begin rhs = m_new; cin = c_mod; end
      OP_ISC: cin = c_in;
      OP_SBX: begin lhs = a_in & x_in; rhs = ~m_in; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
  assign ovf    = (lhs[W-1] == rhs[W-1]) && (sum[W-1] != lhs[W-1]);
  assign masked = a_in & m_in;

  always_comb begin
    a_nx   = a_in;
    x_nx   = x_in;
    c_nx   = c_in;
    v_nx   = v_in;
    set_nz = 1'b1;
    nz_src = '0;
    unique case (op)
      OP_SLO: begin a_nx = a_in | m_new; c_nx = c_mod; end
      OP_RLA: begin a_nx = a_in & m_new; c_nx = c_mod; end
      OP_SRE: begin a_nx = a_in ^ m_new; c_nx = c_mod; end
      OP_RRA: begin a_nx = sum[W-1:0]; c_nx = sum[W]; v_nx = ovf; end
      OP_DCP: c_nx = sum[W];
      OP_ISC: begin a_nx = sum[W-1:0]; c_nx = sum[W]; v_nx = ovf; end
      OP_ANC: begin a_nx = masked; c_nx = masked[W-1]; end
      OP_ASR: begin a_nx = {1'b0, masked[W-1:1]}; c_nx = masked[0]; end
      OP_ARR: begin
        a_nx = {c_in, masked[W-1:1]};
        c_nx = masked[W-1];
        v_nx = masked[W-1] ^ masked[W-2];
      end
      OP_SBX: begin x_nx = sum[W-1:0]; c_nx = sum[W]; end
      OP_LAX: begin a_nx = m_in; x_nx = m_in; end
      OP_LXA: begin a_nx = (a_in | LXA_MIX) & m_in; x_nx = (a_in | LXA_MIX) & m_in; end
      default: set_nz = 1'b0;
    endcase
    if (op == OP_SAX) set_nz = 1'b0;
    unique case (op)
      OP_DCP:  nz_src = sum[W-1:0];
      OP_SBX:  nz_src = x_nx;
      default: nz_src = a_nx;
    endcase
    n_nx = set_nz ? nz_src[W-1] : n_in;
    z_nx = set_nz ? (nz_src == '0) : z_in;
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_alu_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] LXA_MIX = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] m_in,
  input  logic         n_in,
  input  logic         z_in,
  input  logic         c_in,
  input  logic         v_in,
  input  logic         d_in,
  output logic         out_valid,
  output logic [W-1:0] a_out,
  output logic [W-1:0] x_out,
  output logic [W-1:0] m_out,
  output logic         m_we,
  output logic         n_out,
  output logic         z_out,
  output logic         c_out,
  output logic         v_out
);
  fused_op_e    op_e;
  logic [W-1:0] m_new, a_nx, x_nx;
  logic         c_mod, we_nx, n_nx, z_nx, c_nx, v_nx;

  assign op_e = fused_op_e'(op);

  rmw_mem_unit #(.W(W)) u_mem (
    .op(op_e), .a_in(a_in), .x_in(x_in), .m_in(m_in), .c_in(c_in),
    .m_new(m_new), .c_mod(c_mod), .we(we_nx)
  );

  rmw_acc_unit #(.W(W), .LXA_MIX(LXA_MIX)) u_acc (
    .op(op_e), .a_in(a_in), .x_in(x_in), .m_in(m_in), .m_new(m_new),
    .c_mod(c_mod), .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
    .a_nx(a_nx), .x_nx(x_nx), .n_nx(n_nx), .z_nx(z_nx), .c_nx(c_nx), .v_nx(v_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      m_we      <= 1'b0;
      a_out     <= '0;
      x_out     <= '0;
      m_out     <= '0;
      {n_out, z_out, c_out, v_out} <= 4'b0;
    end else begin
      out_valid <= in_valid;
      m_we      <= in_valid & we_nx;
      if (in_valid) begin
        a_out <= a_nx;
        x_out <= x_nx;
        m_out <= m_new;
        {n_out, z_out, c_out, v_out} <= {n_nx, z_nx, c_nx, v_nx};
      end
    end
  end
endmodule

// File: rtl/rmw_alu_chk.sv
module rmw_alu_chk
  import rmw_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic [W-1:0] a_in,
  input logic [W-1:0] m_in,
  input logic         n_in,
  input logic         z_in,
  input logic         c_in,
  input logic         v_in,
  input logic         d_in,
  input logic         out_valid,
  input logic         m_we,
  input logic [W-1:0] a_out,
  input logic [W-1:0] x_out,
  input logic         n_out,
  input logic         z_out,
  input logic         c_out,
  input logic         v_out
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R2

  AST_WE_ONLY_WRITERS: assert property (@(posedge clk) disable iff (rst)
    m_we |-> out_valid && ($past(op) <= 4'd5 || $past(op) == 4'd11)); // R12

  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !($past(op) == 4'd3 || $past(op) == 4'd5 || $past(op) == 4'd8)
    |-> v_out == $past(v_in)); // R13

  AST_STORE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) == 4'd11
    |-> {n_out, z_out, c_out} == $past({n_in, z_in, c_in}) && a_out == $past(a_in)); // R9

  AST_LOAD_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op == 4'd12 && m_in == '0) |-> a_out == '0 && x_out == '0); // R10

  AST_BINARY_WITH_D: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op == 4'd3 && d_in)
    |-> a_out == $past(a_in + {c_in, m_in[W-1:1]} + {{(W-1){1'b0}}, m_in[0]})); // R11

  AST_COMPARE_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) == 4'd4 |-> a_out == $past(a_in)); // R5
endmodule

bind rmw_alu rmw_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_rmw_alu.sv
module sim_rmw_alu;
  localparam int W = 8;

  typedef struct packed {
    logic [7:0] a, x, m;
    logic we, n, z, c, v;
  } res_t;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] a_in = '0, x_in = '0, m_in = '0;
  logic n_in = 0, z_in = 0, c_in = 0, v_in = 0, d_in = 0;
  logic out_valid, m_we, n_out, z_out, c_out, v_out;
  logic [W-1:0] a_out, x_out, m_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rmw_alu #(.W(W)) u0 (.*);

  function automatic string tag(input int o);
    case (o)
      0, 1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6, 7, 8: return "R7";
      9: return "R8";
      10, 11: return "R9";
      12: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic res_t model(input int o, input int a, input int x, input int m,
                                 input bit n, input bit z, input bit c, input bit v);
    res_t r; int t, s, mm, res;
    r = '{a: a[7:0], x: x[7:0], m: m[7:0], we: 0, n: n, z: z, c: c, v: v};
    res = -1;
    case (o)
      0: begin mm = (m * 2) % 256; r.c = m >= 128; r.a = 8'(a | mm); r.m = 8'(mm); r.we = 1; end
      1: begin mm = (m * 2) % 256 + int'(c); r.c = m >= 128; r.a = 8'(a & mm); r.m = 8'(mm); r.we = 1; end
      2: begin mm = m / 2; r.c = m % 2; r.a = 8'(a ^ mm); r.m = 8'(mm); r.we = 1; end
      3: begin
        mm = m / 2 + (c ? 128 : 0); s = a + mm + m % 2;
        r.c = s > 255; r.a = 8'(s); r.m = 8'(mm); r.we = 1;
        r.v = (((a ^ s) & (mm ^ s) & 128) != 0);
      end
      4: begin mm = (m + 255) % 256; r.m = 8'(mm); r.we = 1; r.c = a >= mm; res = (a - mm + 256) % 256; end
      5: begin
        mm = (m + 1) % 256; s = a - mm - (c ? 0 : 1);
        r.c = s >= 0; r.a = 8'(s); r.m = 8'(mm); r.we = 1;
        r.v = (((a ^ mm) & (a ^ (s & 255)) & 128) != 0);
      end
      6: begin t = a & m; r.a = 8'(t); r.c = t >= 128; end
      7: begin t = a & m; r.a = 8'(t / 2); r.c = t % 2; end
      8: begin t = (a & m) / 2 + (c ? 128 : 0); r.a = 8'(t); r.c = (t / 64) % 2; r.v = ((t / 64) % 2) != ((t / 32) % 2); end
      9: begin t = (a & x) - m; r.c = t >= 0; r.x = 8'(t); res = t & 255; end
      10: begin r.a = 8'(m); r.x = 8'(m); end
      11: begin r.m = 8'(a & x); r.we = 1; end
      12: begin r.a = 8'(m); r.x = 8'(m); end
      default: ;
    endcase
    if (o <= 10 || o == 12) begin
      if (res < 0) res = int'(r.a);
      r.n = res >= 128; r.z = res == 0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %s expected %s", req, what, got, exp);
    end
  endtask

  // called just after a falling edge: drives, waits one cycle, compares
  task automatic run(input int o, input int a, input int x, input int m,
                     input bit n, input bit z, input bit c, input bit v, input bit d);
    res_t e, g;
    op = 4'(o); a_in = 8'(a); x_in = 8'(x); m_in = 8'(m);
    n_in = n; z_in = z; c_in = c; v_in = v; d_in = d; in_valid = 1;
    e = model(o, a, x, m, n, z, c, v);
    @(negedge clk);
    g = '{a: a_out, x: x_out, m: m_out, we: m_we, n: n_out, z: z_out, c: c_out, v: v_out};
    if (!e.we) begin g.m = '0; e.m = '0; end
    check(out_valid && g == e, tag(o), $sformatf("op %0d", o),
          $sformatf("%h", g), $sformatf("%h", e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    res_t keep;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check({out_valid, m_we, a_out, x_out, m_out, n_out, z_out, c_out, v_out} == '0,
          "R1", "reset outputs", $sformatf("%h", a_out), "0");
    rst = 0;
    @(negedge clk);
    // directed corner cases
    run(12, 8'h5A, 8'h33, 8'h00, 0, 0, 1, 0, 0);     // R10 zero argument clears A and X
    run(3, 8'h7F, 0, 8'h03, 0, 0, 0, 0, 1);          // R4 rotate carry feeds add, overflow; R11 D set
    run(3, 8'hFF, 0, 8'h01, 0, 0, 1, 1, 0);          // R4 carry out
    run(4, 8'h10, 0, 8'h11, 0, 0, 0, 0, 0);          // R5 equal after decrement
    run(4, 8'h00, 0, 8'h00, 0, 0, 1, 1, 0);          // R5 decrement wraps
    run(5, 8'h80, 0, 8'h00, 0, 0, 1, 0, 1);          // R6 overflow, D set (R11)
    run(5, 8'h00, 0, 8'hFF, 0, 0, 0, 0, 0);          // R6 increment wraps
    run(8, 8'hFF, 0, 8'hC0, 0, 0, 1, 0, 0);          // R7 rotate flags
    run(9, 8'hF0, 8'h3C, 8'h31, 0, 0, 0, 1, 0);      // R8 borrow
    run(11, 8'hF0, 8'h3C, 8'h00, 1, 1, 1, 1, 0);     // R9 store keeps flags
    run(14, 8'h12, 8'h34, 8'h56, 1, 0, 1, 0, 0);     // R12 reserved code
    run(0, 8'h01, 0, 8'h80, 0, 0, 0, 1, 0);          // R3 / R13
    // idle cycle: outputs hold, strobe drops (R2)
    keep = '{a: a_out, x: x_out, m: m_out, we: 0, n: n_out, z: z_out, c: c_out, v: v_out};
    in_valid = 0; a_in = 8'hAA; op = 4'd10;
    @(negedge clk);
    check(!out_valid && !m_we && {a_out, x_out, m_out, n_out, z_out, c_out, v_out} ==
          {keep.a, keep.x, keep.m, keep.n, keep.z, keep.c, keep.v},
          "R2", "idle hold", $sformatf("%h", a_out), $sformatf("%h", keep.a));
    // random stimulus, back to back
    for (int i = 0; i < 600; i++)
      run($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
          $urandom_range(0, 255), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule